// File: doc/BRIEF.md
# Serial Receive Buffer with Justification

This block is the receive half of a synchronous serial port. Serial bits arrive most-significant bit first, one per bit-clock enable pulse, and a word begins on the bit where the frame-sync input is high. Finished words pass through three registers: a shift register, a single-word holding buffer, and a data register that the CPU reads. The word is justified as it is copied from the buffer into the data register. Three placements are supported: right with zero-fill, right with sign-extension, and left with zero-fill.

A ready flag tells the CPU that the data register holds an unread word. An overrun flag reports the case where the CPU falls behind and a new word is lost. A sync-error flag reports a frame-sync that arrives while a word is still being shifted in. Software can also write the sync-error flag directly. Everything runs on one system clock. The bit clock is given as a one-cycle enable per serial bit.

Top module: `rxb_top`

## Requirements
- R1: After reset, `dataOut` is 0 and `rdy`, `overrun` and `syncErr` are all low.
- R2: `wordLenSel` is latched on the frame-sync bit. Codes 0, 1, 2, 3, 4 and 5 select 8, 12, 16, 20, 24 and 32 bits. The reserved codes 6 and 7 act as 32 bits. Bits arrive MSB first, and the frame-sync bit is the first data bit.
- R3: With `justMode` 0, the word sits in the low bits of `dataOut` and the upper bits are 0. `justMode` 3 is reserved and gives the same result.
- R4: With `justMode` 1, the word sits in the low bits and its MSB fills every upper bit. A 20-bit word 0xABCDE reads as 0xFFFABCDE.
- R5: With `justMode` 2, the word sits in the high bits and the low bits are 0. A 20-bit word 0xABCDE reads as 0xABCDE000. `justMode` is applied at the moment of the buffer-to-data copy.
- R6: Timing of the ready flag:
  - When the data register is free, `rdy` rises on the second clock edge after the edge that takes in a word's last bit.
  - `rdy` falls on the edge where `rdStrobe` is high.
  - `dataOut` does not change while `rdy` is high.
- R7: Overrun behaviour:
  - `overrun` is set when a word completes while `rdy` is high and the buffer already holds a word.
  - The new word is dropped and the buffered word is kept.
  - A read clears `overrun`, and the buffered word then moves into the data register.
- R8: A frame-sync during a word sets `syncErr`. The partial word is dropped, and reception restarts with that bit as the first bit of a new word.
- R9: When `errWr` is high, `syncErr` takes the value of `errWrVal`. A sync error detected in the same cycle takes priority.
- R10: Cycles with `bitEn` low shift nothing. Bits with `bitEn` high that arrive outside a word without frame-sync are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serDat | input | 1 | Serial data bit |
| bitEn | input | 1 | Bit-clock enable, one cycle per serial bit |
| frameSync | input | 1 | Marks the first bit of a word |
| wordLenSel | input | 3 | Word length code |
| justMode | input | 2 | Justification mode |
| rdStrobe | input | 1 | CPU read of the data register |
| errWr | input | 1 | Write strobe for the sync-error flag |
| errWrVal | input | 1 | Value written to the sync-error flag |
| dataOut | output | 32 | Justified data register |
| rdy | output | 1 | Data register holds an unread word |
| overrun | output | 1 | A word was lost because the CPU read late |
| syncErr | output | 1 | Unexpected frame-sync flag |

## Verification
A wrong bit counter or a wrong latched length shows up at the first word as a shifted or truncated `dataOut`. It also moves the `rdy` rise away from its expected cycle, which is two edges after the last bit. A buffer-full state that is lost or stuck shows up in the overrun sequence. Either a second word never reaches `dataOut` after the read, or a dropped word appears in its place, within three cycles of the read. A bit counter that is not cleared after an aborted word shows up on the very next word as wrong data.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int DATA_W  = 32;
  localparam int LSEL_W  = 3;
  localparam int MODE_W  = 2;
  localparam int CNT_W   = $clog2(DATA_W + 1);

  typedef enum logic [MODE_W-1:0] {
    JUST_RZERO = 2'd0,
    JUST_RSIGN = 2'd1,
    JUST_LZERO = 2'd2,
    JUST_RSVD  = 2'd3
  } justMode_e;

  typedef struct packed {
    logic             startWord;
    logic             shiftEn;
    logic             loadBuf;
    logic             loadData;
    logic [CNT_W-1:0] wordLen;
  } rxStrobe_t;

  function automatic logic [CNT_W-1:0] lenDecode(input logic [LSEL_W-1:0] code);
    case (code)
      3'd0:    return CNT_W'(8);
      3'd1:    return CNT_W'(12);
      3'd2:    return CNT_W'(16);
      3'd3:    return CNT_W'(20);
      3'd4:    return CNT_W'(24);
      default: return CNT_W'(DATA_W);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] justify(input logic [DATA_W-1:0] word,
                                                input logic [CNT_W-1:0]  len,
                                                input logic [MODE_W-1:0] mode);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] low;
    logic              msb;
    mask = (int'(len) >= DATA_W) ? '1 : ((DATA_W'(1) << len) - DATA_W'(1));
    low  = word & mask;
    msb  = word[len - CNT_W'(1)];
    case (justMode_e'(mode))
      JUST_RSIGN: return msb ? (low | ~mask) : low;
      JUST_LZERO: return low << (CNT_W'(DATA_W) - len);
      default:    return low;
    endcase
  endfunction
endpackage

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
  import rxb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              frameSync,
  input  logic [LSEL_W-1:0] wordLenSel,
  input  logic              rdStrobe,
  input  logic              errWr,
  input  logic              errWrVal,
  output rxStrobe_t         strobe,
  output logic              rdy,
  output logic              overrun,
  output logic              syncErr
);
  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] curLen;
  logic             bufFull;
  logic             startWord, wordDone, drain, loadBuf, ovrEvent, syncEvent;

  always_comb begin
    startWord = bitEn && frameSync;
    syncEvent = startWord && busy;
    wordDone  = bitEn && busy && !frameSync && (bitCnt == curLen - CNT_W'(1));
    drain     = bufFull && !rdy;
    loadBuf   = wordDone && (!bufFull || drain);
    ovrEvent  = wordDone && bufFull && !drain;
    strobe.startWord = startWord;
    strobe.shiftEn   = bitEn && (busy || frameSync);
    strobe.loadBuf   = loadBuf;
    strobe.loadData  = drain;
    strobe.wordLen   = curLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      bitCnt  <= '0;
      curLen  <= CNT_W'(DATA_W);
      bufFull <= 1'b0;
      rdy     <= 1'b0;
      overrun <= 1'b0;
      syncErr <= 1'b0;
    end else begin
      if (startWord) begin
        busy   <= 1'b1;
        bitCnt <= CNT_W'(1);
        curLen <= lenDecode(wordLenSel);
      end else if (bitEn && busy) begin
        if (wordDone) begin
          busy   <= 1'b0;
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end

      if (loadBuf)    bufFull <= 1'b1;
      else if (drain) bufFull <= 1'b0;

      if (drain)         rdy <= 1'b1;
      else if (rdStrobe) rdy <= 1'b0;

      if (ovrEvent)      overrun <= 1'b1;
      else if (rdStrobe) overrun <= 1'b0;

      if (syncEvent)  syncErr <= 1'b1;
      else if (errWr) syncErr <= errWrVal;
    end
  end

  AST_RDY_FROM_BUF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdy) |-> $past(bufFull)); // R6
  AST_READ_CLEARS_RDY: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdy) |=> !rdy); // R6
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(rdy) && $past(bufFull))); // R7
  AST_SYNC_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && frameSync && busy) |=> syncErr); // R8
endmodule

// File: rtl/rxb_dp.sv
module rxb_dp
  import rxb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serDat,
  input  logic [MODE_W-1:0] justMode,
  input  rxStrobe_t         strobe,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftNext;
  logic [DATA_W-1:0] bufReg;
  logic [CNT_W-1:0]  bufLen;

  always_comb begin
    if (strobe.startWord) shiftNext = {{(DATA_W-1){1'b0}}, serDat};
    else                  shiftNext = {shiftReg[DATA_W-2:0], serDat};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bufReg   <= '0;
      bufLen   <= CNT_W'(DATA_W);
      dataOut  <= '0;
    end else begin
      if (strobe.shiftEn) shiftReg <= shiftNext;
      if (strobe.loadBuf) begin
        bufReg <= shiftNext;
        bufLen <= strobe.wordLen;
      end
      if (strobe.loadData) dataOut <= justify(bufReg, bufLen, justMode);
    end
  end

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBuf |-> (strobe.wordLen inside {CNT_W'(8), CNT_W'(12), CNT_W'(16),
                                               CNT_W'(20), CNT_W'(24), CNT_W'(32)})); // R2
  AST_ONE_LOAD_SRC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBuf |-> strobe.shiftEn); // R2
endmodule

// File: rtl/rxb_top.sv
module rxb_top
  import rxb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        serDat,
  input  logic        bitEn,
  input  logic        frameSync,
  input  logic [2:0]  wordLenSel,
  input  logic [1:0]  justMode,
  input  logic        rdStrobe,
  input  logic        errWr,
  input  logic        errWrVal,
  output logic [31:0] dataOut,
  output logic        rdy,
  output logic        overrun,
  output logic        syncErr
);
  rxStrobe_t strobe;

  rxb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync),
    .wordLenSel(wordLenSel), .rdStrobe(rdStrobe), .errWr(errWr),
    .errWrVal(errWrVal), .strobe(strobe), .rdy(rdy), .overrun(overrun),
    .syncErr(syncErr)
  );

  rxb_dp dp_i (
    .clk(clk), .rstN(rstN), .serDat(serDat), .justMode(justMode),
    .strobe(strobe), .dataOut(dataOut)
  );

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rdy |=> $stable(dataOut)); // R6
  AST_OVR_IMPLIES_RDY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> rdy); // R7
endmodule

// File: tb/rxb_top_tb_top.sv
module rxb_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serDat = 1'b0, bitEn = 1'b0, frameSync = 1'b0;
  logic [2:0]  wordLenSel = 3'd0;
  logic [1:0]  justMode = 2'd0;
  logic        rdStrobe = 1'b0, errWr = 1'b0, errWrVal = 1'b0;
  logic [31:0] dataOut;
  logic        rdy, overrun, syncErr;

  int nChecks = 0;
  int nFail = 0;
  bit autoRead = 1'b0;
  bit doneFlag = 1'b0;
  logic [31:0] expQ[$];

  always #2 clk = ~clk;

  rxb_top dut_i (
    .clk(clk), .rstN(rstN), .serDat(serDat), .bitEn(bitEn), .frameSync(frameSync),
    .wordLenSel(wordLenSel), .justMode(justMode), .rdStrobe(rdStrobe),
    .errWr(errWr), .errWrVal(errWrVal), .dataOut(dataOut), .rdy(rdy),
    .overrun(overrun), .syncErr(syncErr)
  );

  function automatic int lenOf(input logic [2:0] code);
    int tbl[6] = '{8, 12, 16, 20, 24, 32};
    return (code > 3'd5) ? 32 : tbl[code];
  endfunction

  function automatic logic [31:0] expJust(input logic [31:0] val, input int len,
                                          input logic [1:0] mode);
    logic [63:0] low;
    low = {32'd0, val} & ((64'd1 << len) - 64'd1);
    if (mode == 2'd1 && val[len-1]) return low[31:0] | ~((32'd1 << (len % 32)) - 32'd1) & {32{len != 32}};
    if (mode == 2'd2) return (low << (32 - len)) & 64'hFFFF_FFFF;
    return low[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [2:0] code, input logic [31:0] val, input int nb);
    int len = lenOf(code);
    wordLenSel = code;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      serDat = val[len-1-i];
      frameSync = (i == 0);
      bitEn = 1'b1;
      @(negedge clk);
      bitEn = 1'b0;
      frameSync = 1'b0;
      serDat = 1'($urandom);
    end
  endtask

  task automatic sendWord(input logic [2:0] code, input logic [31:0] val);
    sendBits(code, val, lenOf(code));
    expQ.push_back(expJust(val, lenOf(code), justMode));
  endtask

  // monitor: reads the data register and compares against the scoreboard
  always @(negedge clk) begin
    if (rdStrobe) rdStrobe <= 1'b0;
    else if (autoRead && rdy && rstN) begin
      if (expQ.size() == 0) check(1'b0, "R7 unexpected word", dataOut, 32'h0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(dataOut === e, "R2/R3/R4/R5 data", dataOut, e);
      end
      rdStrobe <= 1'b1;
    end
  end

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] vals[4] = '{32'h000ABCDE, 32'h0000005A, 32'hF00FA5C3, 32'h12345678};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dataOut == 0 && !rdy && !overrun && !syncErr, "R1 reset", {rdy, overrun, syncErr}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R6 ready timing, reading disabled
    sendWord(3'd0, 32'hA5);
    check(rdy == 1'b0, "R6 rdy one edge after last bit", rdy, 0);
    @(negedge clk);
    check(rdy == 1'b1, "R6 rdy two edges after last bit", rdy, 1);
    autoRead = 1'b1;
    repeat (3) @(negedge clk);
    check(rdy == 1'b0, "R6 rdy cleared by read", rdy, 0);

    // R2 R3 R4 R5: named example in every mode
    for (int m = 0; m < 4; m++) begin
      justMode = 2'(m);
      sendWord(3'd3, 32'h000ABCDE);
      repeat (6) @(negedge clk);
    end
    // all length codes (incl. reserved 6, 7) under every mode
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 8; c++) begin
        justMode = 2'(m);
        sendWord(3'(c), vals[c % 4] ^ 32'(c * 32'h01010101));
        repeat (6) @(negedge clk);
      end
    end

    // R10: stray bits without frame-sync are ignored
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); serDat = 1'b1; bitEn = 1'b1;
      @(negedge clk); bitEn = 1'b0;
    end
    repeat (4) @(negedge clk);
    check(rdy == 1'b0 && expQ.size() == 0, "R10 idle bits ignored", rdy, 0);
    justMode = 2'd0;
    sendWord(3'd1, 32'h00000C3A);
    repeat (6) @(negedge clk);

    // R7 overrun
    autoRead = 1'b0;
    justMode = 2'd0;
    sendWord(3'd0, 32'h11);
    sendWord(3'd0, 32'h22);
    sendBits(3'd0, 32'h33, 8);
    @(negedge clk);
    check(overrun == 1'b1, "R7 overrun set", overrun, 1);
    check(dataOut == 32'h11, "R7 data kept during overrun", dataOut, 32'h11);
    autoRead = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(overrun == 1'b0, "R7 overrun cleared by read", overrun, 0);
    repeat (6) @(negedge clk);
    check(expQ.size() == 0 && rdy == 1'b0, "R7 buffered word delivered, new word dropped",
          32'(expQ.size()), 0);

    // R8 unexpected frame-sync restarts word
    check(syncErr == 1'b0, "R8 no error before", syncErr, 0);
    sendBits(3'd0, 32'hFF, 5);
    sendWord(3'd0, 32'h6C);
    repeat (6) @(negedge clk);
    check(syncErr == 1'b1, "R8 sync error flagged", syncErr, 1);
    check(expQ.size() == 0, "R8 restarted word received", 32'(expQ.size()), 0);

    // R9 software write of the flag
    @(negedge clk); errWr = 1'b1; errWrVal = 1'b0;
    @(negedge clk); errWr = 1'b0;
    check(syncErr == 1'b0, "R9 write 0 clears", syncErr, 0);
    errWr = 1'b1; errWrVal = 1'b1;
    @(negedge clk); errWr = 1'b0;
    check(syncErr == 1'b1, "R9 write 1 sets", syncErr, 1);
    errWr = 1'b1; errWrVal = 1'b0;
    @(negedge clk); errWr = 1'b0;
    check(syncErr == 1'b0, "R9 write 0 clears again", syncErr, 0);

    repeat (4) @(negedge clk);
    check(rdy == 1'b0 && expQ.size() == 0, "R6 nothing pending at end", rdy, 0);
    finishRun();
  end
endmodule